// File: doc/BRIEF.md
# Delayed-Parity Command Error Detector

This block watches a registered address/command bus and checks each selected command word against a parity bit. The parity bit arrives one clock after the word it covers. The word and its qualification are held for one cycle so that they line up with the late parity bit. A mismatch then drives an active-low error line after a fixed latency.

The error line behaves like an open-drain pin. The block gives a drive-enable and a data value that is always low. A pull-up outside the block makes the line read high whenever it is not driven. While the line is driven low for one error, further failing words extend the low window. The release always falls a fixed number of cycles after the most recent failing word.

Words are only checked when at least one chip-select is active. A run-time mode input chooses whether two or four chip-selects take part in that decision. The chip-select, clock-enable and termination inputs that depend on the module population are accepted but never enter the check.

Top module: `cmdpar_top`

## Requirements
- R1: The word on `cmdWord` is captured on rising edge E. The parity bit on `parIn` is captured on edge E+1. The pair fails when the XOR of all word bits and the parity bit equals 1 (even parity).
- R2: A word fails only if it was qualified when captured, meaning at least one considered bit of `csN` was 0 (active low). A word with every considered select at 1 never causes an error.
- R3: With `quadMode`=1, bits 3..0 of `csN` are considered. With `quadMode`=0, only bits 1..0 are considered, and bits 3..2 have no effect. The mode is sampled together with the word.
- R4: `dimmCsN`, `dimmCke` and `dimmOdt` have no effect on the error line.
- R5: For a failing word captured on edge E, `errDriveEn` rises on edge E+3.
- R6: `errDriveEn` falls on edge L+5, where L is the capture edge of the last failing word. Failing words on consecutive or nearby cycles merge into one continuous low window.
- R7: Once the line is driven low, it stays low for at least two clock cycles unless reset is asserted.
- R8: While `rstN` is 0, the line is released at once and no checking takes place. Errors still pending in the pipeline when reset is asserted never appear.
- R9: `errOutN` is 0 at all times. The resolved line level is 0 when `errDriveEn` is 1 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWord | input | CMD_W | Address/command word covered by parity |
| csN | input | 4 | Active-low chip-selects that qualify the word |
| quadMode | input | 1 | 1: four selects qualify, 0: two selects qualify |
| dimmCsN | input | 2 | Population-dependent selects, excluded from the check |
| dimmCke | input | 2 | Population-dependent clock enables, excluded from the check |
| dimmOdt | input | 2 | Population-dependent termination controls, excluded from the check |
| parIn | input | 1 | Parity bit for the word sampled one edge earlier |
| errOutN | output | 1 | Open-drain data value, always 0 |
| errDriveEn | output | 1 | 1 while the error line is pulled low |

## Verification
The hardest case to reach from the ports is two or more low windows overlapping. The release edge is then set by the latest failing word and not the first. Reaching it needs failing words back to back and one idle cycle apart.

Directed sequences build these cases. They also cover a reset asserted in the middle of a low window. They place bad parity on words whose only active selects are the upper two in two-select mode. Biased random traffic then mixes good and bad parity, all select patterns and both modes. A bench model holds a four-deep history of failing words and predicts the line level on every cycle.

// File: rtl/cmdpar_pkg.sv
package cmdpar_pkg;
  localparam int CS_MAX = 4;   // selects in quad mode
  localparam int CS_DUAL = 2;  // selects in two-select mode

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic compareEn;  // parity compare permitted on this edge
    logic captureEn;  // word/qualifier capture permitted
  } cmdpar_strobe_t;
endpackage

// File: rtl/cmdpar_datapath.sv
module cmdpar_datapath
  import cmdpar_pkg::*;
#(
  parameter int CMD_W = 26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdpar_strobe_t       strobes,
  input  logic [CMD_W-1:0]     cmdWord,
  input  logic [CS_MAX-1:0]    csN,
  input  logic                 quadMode,
  input  logic                 parIn,
  output logic                 mismatchQ
);
  logic [CMD_W-1:0] wordQ;
  logic             qualQ;
  logic             anySel;
  logic             oddSum;

  // qualification: any active select among the ones the mode considers
  always_comb begin
    if (quadMode) anySel = ~(&csN);
    else          anySel = ~(&csN[CS_DUAL-1:0]);
  end

  // word and qualifier travel together for one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      qualQ <= 1'b0;
    end else if (strobes.captureEn) begin
      wordQ <= cmdWord;
      qualQ <= anySel;
    end
  end

  // even parity: XOR of word and late parity bit must be zero
  assign oddSum = ^{wordQ, parIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mismatchQ <= 1'b0;
    else       mismatchQ <= strobes.compareEn & qualQ & oddSum;
  end

  // R2: an unqualified word never yields a mismatch
  p_unqualified_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    !qualQ |=> !mismatchQ);
endmodule

// File: rtl/cmdpar_ctrl.sv
module cmdpar_ctrl
  import cmdpar_pkg::*;
#(
  parameter int ERR_LAT = 3,  // edges from word capture to drive
  parameter int HOLD    = 2   // edges the line stays low per trigger
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           mismatchIn,
  output cmdpar_strobe_t strobes,
  output logic           errDriveEn
);
  localparam int DLY   = ERR_LAT - 2;            // stages after the compare flop
  localparam int CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;

  logic             armedQ;
  logic [DLY-1:0]   latPipe;
  logic             trigger;
  logic [CNT_W-1:0] holdCnt;

  initial begin
    if (ERR_LAT < 3) $error("ERR_LAT must be at least 3");
    if (HOLD < 1)    $error("HOLD must be at least 1");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  assign strobes.captureEn = 1'b1;
  assign strobes.compareEn = armedQ;

  // latency pipe between the compare result and the drive decision
  generate
    if (DLY == 1) begin : g_lat_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) latPipe <= '0;
        else       latPipe <= mismatchIn;
      end
    end else begin : g_lat_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) latPipe <= '0;
        else       latPipe <= {latPipe[DLY-2:0], mismatchIn};
      end
    end
  endgenerate

  assign trigger = latPipe[DLY-1];

  // each trigger restarts the low window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errDriveEn <= 1'b0;
      holdCnt    <= '0;
    end else if (trigger) begin
      errDriveEn <= 1'b1;
      holdCnt    <= CNT_W'(HOLD - 1);
    end else if (holdCnt != '0) begin
      holdCnt    <= holdCnt - 1'b1;
    end else begin
      errDriveEn <= 1'b0;
    end
  end

  // R5: a compare failure reaches the line after the fixed latency
  p_fixed_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    mismatchIn |-> ##(ERR_LAT-1) errDriveEn);

  // R6: window ends once the count runs out with no new trigger
  p_release_on_time_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errDriveEn && holdCnt == '0 && !trigger) |=> !errDriveEn);

  // R7: minimum low time
  p_min_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errDriveEn) |=> errDriveEn);
endmodule

// File: rtl/cmdpar_top.sv
module cmdpar_top
  import cmdpar_pkg::*;
#(
  parameter int CMD_W   = 26,
  parameter int ERR_LAT = 3,
  parameter int HOLD    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [3:0]        csN,
  input  logic              quadMode,
  input  logic [1:0]        dimmCsN,
  input  logic [1:0]        dimmCke,
  input  logic [1:0]        dimmOdt,
  input  logic              parIn,
  output logic              errOutN,
  output logic              errDriveEn
);
  cmdpar_strobe_t strobes;
  logic           mismatchQ;

  cmdpar_datapath #(.CMD_W(CMD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmdWord   (cmdWord),
    .csN       (csN),
    .quadMode  (quadMode),
    .parIn     (parIn),
    .mismatchQ (mismatchQ)
  );

  cmdpar_ctrl #(.ERR_LAT(ERR_LAT), .HOLD(HOLD)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mismatchIn (mismatchQ),
    .strobes    (strobes),
    .errDriveEn (errDriveEn)
  );

  // open-drain data value is fixed low
  assign errOutN = 1'b0;

  // R8: line released whenever reset is low
  p_released_in_reset_r8: assert property (@(posedge clk)
    !rstN |-> !errDriveEn);

  // R4: excluded inputs are accepted but must be driven to known levels
  p_excluded_known_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({dimmCsN, dimmCke, dimmOdt}));
endmodule

// File: tb/sim_cmdpar_top.sv
module sim_cmdpar_top;
  localparam int CLK_P = 10;
  localparam int CMD_W = 26;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CMD_W-1:0] cmdWord = '0;
  logic [3:0]       csN = 4'hF;
  logic             quadMode = 1'b0;
  logic [1:0]       dimmCsN = '1, dimmCke = '0, dimmOdt = '0;
  logic             parIn = 1'b0;
  logic             errOutN, errDriveEn;
  logic             pinLvl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  logic [CMD_W-1:0] prevWord = '0;
  logic             prevQual = 1'b0;
  logic             pendPar = 1'b0;
  logic [3:0]       hist = '0;

  always #(CLK_P/2) clk = ~clk;

  // pull-up resolution of the open-drain line
  assign pinLvl = errDriveEn ? errOutN : 1'b1;

  cmdpar_top #(.CMD_W(CMD_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .csN(csN), .quadMode(quadMode),
    .dimmCsN(dimmCsN), .dimmCke(dimmCke), .dimmOdt(dimmOdt), .parIn(parIn),
    .errOutN(errOutN), .errDriveEn(errDriveEn)
  );

  function automatic logic qualOf(input logic [3:0] cs, input logic q);
    return q ? ~(&cs) : ~(&cs[1:0]);
  endfunction

  function automatic logic failOf(input logic [CMD_W-1:0] w, input logic p);
    return ^w ^ p;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one command cycle; parity sent now covers the previous word
  task automatic issue(input logic [CMD_W-1:0] w, input logic [3:0] cs,
                       input logic q, input logic [5:0] dimm, input logic bad,
                       input string tag);
    logic errNow;
    @(negedge clk);
    cmdWord = w; csN = cs; quadMode = q; parIn = pendPar;
    {dimmCsN, dimmCke, dimmOdt} = dimm;
    @(posedge clk);
    errNow = prevQual & failOf(prevWord, pendPar);
    hist = {hist[2:0], errNow};
    prevWord = w;
    prevQual = qualOf(cs, q);
    pendPar = (^w) ^ bad;
    #1;
    check(tag, pinLvl, ~(hist[2] | hist[3]));
    check("R9 data value", errOutN, 1'b0);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue('0, 4'hF, 1'b1, 6'b110000, 1'b0, tag);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R8 reset releases", pinLvl, 1'b1);
    prevWord = '0; prevQual = 1'b0; pendPar = 1'b0; hist = '0;
    @(negedge clk);
    #1;
    check("R8 held in reset", pinLvl, 1'b1);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    #1;
    check("R8 initial release", pinLvl, 1'b1);
    #(CLK_P * 2);
    rstN = 1'b1;
    idle(3, "R8 quiet after reset");

    // single failing word: low on edges +3 and +4 only
    issue(26'h0A5_1234, 4'b1110, 1'b0, 6'b110000, 1'b1, "R1 R5");
    idle(7, "R5 R6 R7 single window");

    // good parity, qualified: no error
    issue(26'h3FF_FFFF, 4'b1101, 1'b0, 6'b110000, 1'b0, "R1 good parity");
    idle(6, "R1 no error");

    // consecutive failing words extend the window
    issue(26'h000_0001, 4'b0111, 1'b1, 6'b110000, 1'b1, "R6 first");
    issue(26'h000_0003, 4'b1011, 1'b1, 6'b110000, 1'b1, "R6 second");
    issue(26'h000_0007, 4'b1110, 1'b1, 6'b110000, 1'b1, "R6 third");
    idle(8, "R6 consecutive release");

    // failing words one idle apart merge into one window
    issue(26'h12_3456, 4'b1100, 1'b0, 6'b110000, 1'b1, "R6 gap first");
    idle(1, "R6 gap");
    issue(26'h12_3457, 4'b1100, 1'b0, 6'b110000, 1'b1, "R6 gap second");
    idle(8, "R6 merged window");

    // unqualified bad parity is ignored
    issue(26'h155_5555, 4'b1111, 1'b1, 6'b110000, 1'b1, "R2 unqualified");
    idle(6, "R2 no error");

    // upper selects ignored in two-select mode, counted in quad mode
    issue(26'h0F0_F0F0, 4'b0011, 1'b0, 6'b110000, 1'b1, "R3 dual ignores upper");
    idle(6, "R3 dual no error");
    issue(26'h0F0_F0F0, 4'b0011, 1'b1, 6'b110000, 1'b1, "R3 quad counts upper");
    idle(6, "R3 quad error");

    // excluded inputs toggled on good-parity words
    for (int i = 0; i < 16; i++)
      issue(CMD_W'(i * 32'h9E37), 4'b1110, 1'b0, 6'(i * 7 + 1), 1'b0, "R4 excluded inputs");
    idle(6, "R4 no error");

    // reset in the middle of a low window and with an error pending
    issue(26'h2AA_AAAA, 4'b1110, 1'b0, 6'b110000, 1'b1, "R8 pre-reset");
    idle(3, "R8 window active");
    applyReset();
    idle(5, "R8 window cleared");
    issue(26'h2AA_AAAB, 4'b1110, 1'b0, 6'b110000, 1'b1, "R8 pending");
    idle(1, "R8 pending compare");
    applyReset();
    idle(6, "R8 pending dropped");

    // biased random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [CMD_W-1:0] w;
      logic [3:0] cs;
      logic [5:0] dm;
      logic q, bad;
      w   = CMD_W'($urandom);
      cs  = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom);
      q   = 1'($urandom);
      dm  = 6'($urandom);
      bad = ($urandom_range(0, 9) < 2);
      issue(w, cs, q, dm, bad, "R1 R2 R3 R5 R6 random");
    end
    idle(8, "R6 random drain");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule